// File: doc/BRIEF.md
# Timing Reference Framer with Resync Control

This block runs on the serial bit clock. It takes an already decoded serial video bit stream and finds the 10-bit word boundary in it. At every bit position it looks for the four-word timing reference. The reference is one all-ones word, then two all-zeros words, then a marker word. Bits arrive least significant first. When a reference is found, the block reports it, deserialises the stream into parallel words and produces a divide-by-ten word clock. The rising edge of that clock falls in the middle of each word's data window.

The word phase is not always re-aligned to a reference found at a new position. A frame-enable input decides. When frame-enable is low, a misplaced reference only raises a sticky new-sync-position flag. When frame-enable is high, the word phase is moved onto the reference. If frame-enable is driven from the flag itself, one stray reference is tolerated, and the phase moves only when a second misplaced reference follows it.

The parallel output comes from the oldest word of a four-word window, so it lags the stream by three words. Because of this lag, the active-low reference flag can cover all four reference words on the output, and the end-of-video flag can mark the marker word.

Top module: `trsf_framer`

## Requirements
- R1: A reference is the 30-bit prefix 0x3FF, 0x000, 0x000, followed by a marker word, each word sent LSB first. It is detected at any of the ten bit offsets. Once the framer is aligned, the parallel output shows the words 0x3FF, 0x000, 0x000 and the marker word on four consecutive word-clock periods.
- R2: A reference whose last bit does not end a word, received while `frame_en` is high, moves the word phase. The next word boundary falls right after the marker's last bit, and `nsp` is low afterwards.
- R3: A misplaced reference received while `frame_en` is low sets `nsp` high. It leaves the word phase unchanged and does not drive `trs_n` low.
- R4: `nsp` stays high until a reference arrives whose last bit ends a word of the current phase. That reference clears `nsp` to low.
- R5: `trs_n` is low for exactly four consecutive output words, from the 0x3FF word to the marker word. This happens for every reference that is in phase or that causes re-alignment. Otherwise `trs_n` is high.
- R6: When `component_mode` is high, `eav_n` is low for the single output word that carries the marker, and only if marker bit 6 is 1 (end of active video). A marker with bit 6 at 0 leaves `eav_n` high.
- R7: When `component_mode` is low, `eav_n` stays high.
- R8: In steady state, `word_clk` is high for 5 bit periods and low for 5. The output word changes only while `word_clk` is low, and it is stable at the rising edge.
- R9: With `frame_en` driven from `nsp`, one misplaced reference only sets `nsp`. A second misplaced reference right after it re-aligns the phase and clears `nsp`.
- R10: During and right after synchronous reset, `word_out` is 0, `word_clk` is low, `trs_n` and `eav_n` are high, and `nsp` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Decoded serial data bit |
| frame_en | input | 1 | Allows re-alignment to a misplaced reference |
| component_mode | input | 1 | High: component (end-of-video flag active); low: composite |
| word_clk | output | 1 | Divide-by-ten word clock |
| word_out | output | 10 | Parallel output word |
| trs_n | output | 1 | Active-low timing reference flag, four words long |
| eav_n | output | 1 | Active-low end-of-active-video flag on the marker word |
| nsp | output | 1 | New sync position flag |

## Verification
The bench builds the framer with its defaults: 10-bit words and marker bit 6 as the end-of-video bit. With these values, bit slips of 2, 3, 4, 5, 6 and 7 positions can be inserted into the stream. Each slip moves the next reference to a different one of the ten phases, or back to the locked one. A repeating filler word that has no rotational symmetry shows whether the output is aligned. It is used to check the hold case, the re-align case and the tied two-strike case.

// File: rtl/trsf_pkg.sv
package trsf_pkg;

    localparam int WORD_W_DEF  = 10;
    localparam int EAV_BIT_DEF = 6;
    localparam int REF_WORDS   = 4;

    typedef enum logic [1:0] {
        REF_NONE    = 2'd0,
        REF_INPHASE = 2'd1,
        REF_SHIFT   = 2'd2,
        REF_IGNORE  = 2'd3
    } ref_kind_t;

    typedef struct packed {
        logic trs_n;
        logic eav_n;
    } ref_flags_t;

endpackage

// File: rtl/trsf_window.sv
module trsf_window
    import trsf_pkg::*;
#(
    parameter int WORD_W  = WORD_W_DEF,
    parameter int EAV_BIT = EAV_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_bit,
    output logic              hit,
    output logic              hit_eav,
    output logic [WORD_W-1:0] old_word
);
    localparam int WIN_W = REF_WORDS * WORD_W;
    localparam int PRE_W = (REF_WORDS - 1) * WORD_W;

    logic [WIN_W-1:0] win;
    logic [PRE_W-1:0] prefix;

    // newest bit enters at the top; word bit k of the oldest word sits at win[k]
    always_ff @(posedge clk) begin
        if (rst) win <= '0;
        else     win <= {ser_bit, win[WIN_W-1:1]};
    end

    genvar g;
    generate
        for (g = 0; g < PRE_W; g++) begin : g_prefix
            if (g < WORD_W) begin : g_one
                assign prefix[g] = 1'b1;
            end else begin : g_zero
                assign prefix[g] = 1'b0;
            end
        end
    endgenerate

    assign hit      = (win[PRE_W-1:0] == prefix);
    assign hit_eav  = win[PRE_W + EAV_BIT];
    assign old_word = win[WORD_W-1:0];

endmodule

// File: rtl/trsf_phase.sv
module trsf_phase
    import trsf_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  logic      frame_en,
    output ref_kind_t kind,
    output logic      boundary,
    output logic      nsp,
    output logic      word_clk
);
    localparam int CW   = $clog2(WORD_W);
    localparam int HALF = WORD_W / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;
    logic          at_zero;

    assign at_zero = (cnt == '0);

    always_comb begin
        if (!hit)         kind = REF_NONE;
        else if (at_zero) kind = REF_INPHASE;
        else if (frame_en) kind = REF_SHIFT;
        else              kind = REF_IGNORE;
    end

    assign boundary = at_zero || (kind == REF_SHIFT);

    always_comb begin
        if (boundary)                    nxt = CW'(1);
        else if (cnt == CW'(WORD_W - 1)) nxt = '0;
        else                             nxt = cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            word_clk <= 1'b0;
            nsp      <= 1'b0;
        end else begin
            cnt      <= nxt;
            word_clk <= (nxt == '0) || (nxt > CW'(HALF));
            case (kind)
                REF_INPHASE, REF_SHIFT: nsp <= 1'b0;
                REF_IGNORE:             nsp <= 1'b1;
                default:                nsp <= nsp;
            endcase
        end
    end

endmodule

// File: rtl/trsf_flags.sv
module trsf_flags
    import trsf_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  ref_kind_t         kind,
    input  logic              hit_eav,
    input  logic              component_mode,
    input  logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] word_out,
    output ref_flags_t        flags
);
    localparam int LW = $clog2(REF_WORDS);

    logic [LW-1:0] left;
    logic          eav_pend;
    logic          load;

    assign load = (kind == REF_INPHASE) || (kind == REF_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            flags    <= '{trs_n: 1'b1, eav_n: 1'b1};
            left     <= '0;
            eav_pend <= 1'b0;
        end else if (boundary) begin
            word_out <= old_word;
            if (load) begin
                flags    <= '{trs_n: 1'b0, eav_n: 1'b1};
                left     <= LW'(REF_WORDS - 1);
                eav_pend <= hit_eav && component_mode;
            end else if (left != '0) begin
                left        <= left - LW'(1);
                flags.trs_n <= 1'b0;
                flags.eav_n <= !((left == LW'(1)) && eav_pend && component_mode);
            end else begin
                flags <= '{trs_n: 1'b1, eav_n: 1'b1};
            end
        end
    end

endmodule

// File: rtl/trsf_framer.sv
module trsf_framer
    import trsf_pkg::*;
#(
    parameter int WORD_W  = WORD_W_DEF,
    parameter int EAV_BIT = EAV_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_bit,
    input  logic              frame_en,
    input  logic              component_mode,
    output logic              word_clk,
    output logic [WORD_W-1:0] word_out,
    output logic              trs_n,
    output logic              eav_n,
    output logic              nsp
);
    logic              ref_hit;
    logic              ref_eav;
    logic [WORD_W-1:0] old_word;
    logic              boundary;
    ref_kind_t         ref_kind;
    ref_flags_t        flags;

    trsf_window #(.WORD_W(WORD_W), .EAV_BIT(EAV_BIT)) u_window (
        .clk      (clk),
        .rst      (rst),
        .ser_bit  (ser_bit),
        .hit      (ref_hit),
        .hit_eav  (ref_eav),
        .old_word (old_word)
    );

    trsf_phase #(.WORD_W(WORD_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .hit      (ref_hit),
        .frame_en (frame_en),
        .kind     (ref_kind),
        .boundary (boundary),
        .nsp      (nsp),
        .word_clk (word_clk)
    );

    trsf_flags #(.WORD_W(WORD_W)) u_flags (
        .clk            (clk),
        .rst            (rst),
        .boundary       (boundary),
        .kind           (ref_kind),
        .hit_eav        (ref_eav),
        .component_mode (component_mode),
        .old_word       (old_word),
        .word_out       (word_out),
        .flags          (flags)
    );

    assign trs_n = flags.trs_n;
    assign eav_n = flags.eav_n;

endmodule

// File: rtl/trsf_framer_chk.sv
module trsf_framer_chk
    import trsf_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF
) (
    input logic      clk,
    input logic      rst,
    input logic      hit,
    input ref_kind_t kind,
    input logic      frame_en,
    input logic      component_mode,
    input logic      word_clk,
    input logic      trs_n,
    input logic      eav_n,
    input logic      nsp
);
    localparam int HALF = WORD_W / 2;
    localparam int RW   = $clog2(WORD_W) + 2;

    logic [RW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                    low_run <= '0;
        else if (word_clk)          low_run <= '0;
        else if (low_run != '1)     low_run <= low_run + RW'(1);
    end

    // R1: a classified reference always comes from a prefix match
    a_r1_kind_needs_hit: assert property (@(posedge clk) disable iff (rst)
        (kind != REF_NONE) |-> hit);

    // R2: re-alignment clears the flag and starts a new word
    a_r2_realign: assert property (@(posedge clk) disable iff (rst)
        (kind == REF_SHIFT) |=> (!nsp && !word_clk));

    // R3: a held-off misplaced reference raises the flag
    a_r3_hold_sets_nsp: assert property (@(posedge clk) disable iff (rst)
        (hit && kind != REF_INPHASE && !frame_en) |=> nsp);

    // R4: the flag only rises right after a reference
    a_r4_nsp_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(nsp) |-> $past(hit));

    // R6: the end-of-video flag lies inside the reference flag
    a_r6_eav_inside_trs: assert property (@(posedge clk) disable iff (rst)
        !eav_n |-> !trs_n);

    // R7: composite mode keeps the end-of-video flag high
    a_r7_composite_high: assert property (@(posedge clk) disable iff (rst)
        ($stable(component_mode) && !component_mode) |-> eav_n);

    // R8: the word clock low phase is never shorter than half a word
    a_r8_low_min: assert property (@(posedge clk) disable iff (rst)
        $rose(word_clk) |-> (low_run >= RW'(HALF)));

endmodule

bind trsf_framer trsf_framer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .hit            (ref_hit),
    .kind           (ref_kind),
    .frame_en       (frame_en),
    .component_mode (component_mode),
    .word_clk       (word_clk),
    .trs_n          (trs_n),
    .eav_n          (eav_n),
    .nsp            (nsp)
);

// File: tb/trsf_framer_bench.sv
module trsf_framer_bench;
    localparam int W = 10;
    localparam logic [W-1:0] FILL = 10'h0B3;
    localparam logic [W-1:0] XYZ_EAV = 10'h2D8;  // bit 6 set
    localparam logic [W-1:0] XYZ_SAV = 10'h200;  // bit 6 clear

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_bit = 1'b0;
    logic         fe_drv = 1'b1;
    logic         tie = 1'b0;
    logic         component_mode = 1'b1;
    logic         word_clk;
    logic [W-1:0] word_out;
    logic         trs_n;
    logic         eav_n;
    logic         nsp;
    logic         frame_en;

    assign frame_en = tie ? nsp : fe_drv;

    always #2 clk = ~clk;

    trsf_framer u_trsf_framer (
        .clk            (clk),
        .rst            (rst),
        .ser_bit        (ser_bit),
        .frame_en       (frame_en),
        .component_mode (component_mode),
        .word_clk       (word_clk),
        .word_out       (word_out),
        .trs_n          (trs_n),
        .eav_n          (eav_n),
        .nsp            (nsp)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] lw [0:4095];
    logic         lt [0:4095];
    logic         le [0:4095];
    int           nlog = 0;
    logic         prev_wc = 1'b0;
    int           run = 0;
    int           last_hi = 0;
    int           last_lo = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_bit(input logic b);
        @(negedge clk);
        ser_bit = b;
        if (word_clk && !prev_wc && nlog < 4096) begin
            lw[nlog] = word_out;
            lt[nlog] = trs_n;
            le[nlog] = eav_n;
            nlog++;
        end
        if (word_clk == prev_wc) run++;
        else begin
            if (prev_wc) last_hi = run;
            else         last_lo = run;
            run = 1;
        end
        prev_wc = word_clk;
    endtask

    task automatic send_word(input logic [W-1:0] w);
        for (int i = 0; i < W; i++) push_bit(w[i]);
    endtask

    task automatic send_fill(input int n);
        for (int i = 0; i < n; i++) send_word(FILL);
    endtask

    task automatic slip(input int n);
        for (int i = 0; i < n; i++) push_bit(1'b0);
    endtask

    task automatic send_ref(input logic [W-1:0] xyz);
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h000);
        send_word(xyz);
    endtask

    task automatic check_group(input int from, input logic [W-1:0] xyz,
                               input logic exp_eav, input string eav_req);
        int idx = -1;
        for (int i = from; i < nlog; i++)
            if (idx < 0 && lt[i] == 1'b0 && lw[i] == 10'h3FF) idx = i;
        check(idx >= 0, "R5", "reference flag group found", idx, from);
        if (idx >= 0 && idx + 4 < nlog) begin
            check(lw[idx+1] == 0 && lw[idx+2] == 0, "R1", "zero words of reference",
                  int'(lw[idx+1] | lw[idx+2]), 0);
            check(lw[idx+3] == xyz, "R1", "marker word on output", int'(lw[idx+3]), int'(xyz));
            check(!lt[idx+1] && !lt[idx+2] && !lt[idx+3] && lt[idx+4], "R5",
                  "trs_n low for four words",
                  int'({lt[idx+1], lt[idx+2], lt[idx+3], lt[idx+4]}), 1);
            check(le[idx+3] == !exp_eav && le[idx] && le[idx+1] && le[idx+2] && le[idx+4],
                  eav_req, "eav_n only on marker word",
                  int'({le[idx], le[idx+1], le[idx+2], le[idx+3], le[idx+4]}),
                  int'({4'b1111, 1'b1} & {3'b111, !exp_eav, 1'b1}));
        end
    endtask

    task automatic check_no_group(input int from, input string req);
        int found = 0;
        for (int i = from; i < nlog; i++) if (!lt[i]) found++;
        check(found == 0, req, "no reference flag for held-off reference", found, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check(word_out == 0, "R10", "word_out after reset", int'(word_out), 0);
        check(!word_clk && trs_n && eav_n && !nsp, "R10", "flags after reset",
              int'({word_clk, trs_n, eav_n, nsp}), 4'b0110);
    endtask

    task automatic t_lock;
        int mark;
        fe_drv = 1'b1; tie = 1'b0;
        send_fill(3);
        slip(3);
        mark = nlog;
        send_ref(XYZ_EAV);
        send_fill(6);
        check_group(mark, XYZ_EAV, 1'b1, "R6");
        check(lw[nlog-1] == FILL, "R2", "aligned after lock", int'(lw[nlog-1]), int'(FILL));
        check(!nsp, "R2", "nsp low after lock", int'(nsp), 0);
        check(last_hi == 5 && last_lo == 5, "R8", "word clock duty",
              last_hi * 16 + last_lo, 5 * 16 + 5);
    endtask

    task automatic t_inphase_sav;
        int mark;
        fe_drv = 1'b0;
        mark = nlog;
        send_ref(XYZ_SAV);
        send_fill(6);
        check_group(mark, XYZ_SAV, 1'b0, "R6");
        check(!nsp, "R4", "nsp low after in-phase reference", int'(nsp), 0);
    endtask

    task automatic t_hold_fe_low;
        int mark;
        fe_drv = 1'b0; tie = 1'b0;
        slip(4);
        send_fill(2);
        mark = nlog;
        send_ref(XYZ_EAV);
        send_fill(6);
        check(nsp, "R3", "nsp high after misplaced reference", int'(nsp), 1);
        check(lw[nlog-1] != FILL, "R3", "phase unchanged (still misaligned)",
              int'(lw[nlog-1]), int'(FILL));
        check_no_group(mark, "R3");
        slip(6);
        send_fill(2);
        send_ref(XYZ_EAV);
        send_fill(2);
        check(!nsp, "R4", "nsp cleared by in-phase reference", int'(nsp), 0);
        send_fill(4);
        check(lw[nlog-1] == FILL, "R4", "aligned again after slip back",
              int'(lw[nlog-1]), int'(FILL));
    endtask

    task automatic t_tied;
        int mark;
        tie = 1'b1;
        slip(3);
        send_fill(2);
        mark = nlog;
        send_ref(XYZ_EAV);
        send_fill(6);
        check(nsp, "R9", "single misplaced reference sets nsp", int'(nsp), 1);
        check(lw[nlog-1] != FILL, "R9", "single misplaced reference ignored",
              int'(lw[nlog-1]), int'(FILL));
        check_no_group(mark, "R9");
        slip(7);
        send_fill(2);
        mark = nlog;
        send_ref(XYZ_SAV);
        send_fill(6);
        check(!nsp, "R9", "in-phase follow-up clears nsp", int'(nsp), 0);
        check_group(mark, XYZ_SAV, 1'b0, "R6");
        slip(5);
        send_fill(2);
        mark = nlog;
        send_ref(XYZ_EAV);
        send_fill(2);
        send_ref(XYZ_EAV);
        send_fill(6);
        check(!nsp, "R9", "second misplaced reference clears nsp", int'(nsp), 0);
        check(lw[nlog-1] == FILL, "R9", "second misplaced reference re-aligns",
              int'(lw[nlog-1]), int'(FILL));
        check_group(mark, XYZ_EAV, 1'b1, "R6");
        tie = 1'b0;
    endtask

    task automatic t_realign_fe_high;
        int mark;
        fe_drv = 1'b1; tie = 1'b0;
        slip(2);
        send_fill(2);
        mark = nlog;
        send_ref(XYZ_EAV);
        send_fill(6);
        check(!nsp, "R2", "nsp low after re-alignment", int'(nsp), 0);
        check(lw[nlog-1] == FILL, "R2", "re-aligned to reference",
              int'(lw[nlog-1]), int'(FILL));
        check_group(mark, XYZ_EAV, 1'b1, "R6");
    endtask

    task automatic t_composite;
        int mark;
        int lows = 0;
        component_mode = 1'b0;
        send_fill(2);
        mark = nlog;
        send_ref(XYZ_EAV);
        send_fill(6);
        check_group(mark, XYZ_EAV, 1'b0, "R7");
        for (int i = mark; i < nlog; i++) if (!le[i]) lows++;
        check(lows == 0, "R7", "eav_n stays high in composite mode", lows, 0);
        component_mode = 1'b1;
    endtask

    initial begin
        t_reset();
        t_lock();
        t_inphase_sav();
        t_hold_fe_low();
        t_tied();
        t_realign_fe_high();
        t_composite();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1: watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule